// File: doc/BRIEF.md
# Dual-Output Phase-Frequency Detector with Lock Indicator

This block compares two single-cycle edge strobes: one marks each reference period, the other each period of the divided oscillator. It raises one of two active-low pump requests. One request asks the loop to slow the oscillator, because the oscillator runs fast or its phase leads. The other asks the loop to speed it up, because it runs slow or its phase lags. Each request stays low from its own edge until the matching edge on the other stream arrives.

When both edges have arrived, both requests stay low together for a fixed short overlap. Both are then cleared in the same cycle. This overlap means even a zero phase error produces a small, symmetric pulse, so the detector has no dead zone. A lock output is the AND of the two request lines. It reads high with brief low glitches when the loop is locked, and low while either request is active.

A 7-bit control word is written with a strobe. It selects which physical output carries which request, forces both outputs idle through a disable bit or a standby bit, gates the lock output, and carries a 3-bit gain code to the external charge pump. After reset the lock output is held low for a fixed settling time. During that time edges are ignored. All pins are plain level or strobe signals, sampled on the rising clock edge; there is no handshake and no back-pressure.

Top module: `dual_pump_pfd`

## Requirements
- R1: During and straight after reset, both pump outputs are high, the lock output is low and the gain output equals the reset control word (0x10: lock enabled, all else clear, gain 0).
- R2: With the swap bit clear, an oscillator edge alone drives `pump_v_n` low from the cycle after the edge, while `pump_r_n` stays high.
- R3: With the swap bit clear, a reference edge alone drives `pump_r_n` low from the cycle after the edge, while `pump_v_n` stays high.
- R4: With the swap bit set, the two cases trade outputs: an oscillator lead drives `pump_r_n` low and a lag drives `pump_v_n` low.
- R5: Once both requests are pending, both outputs stay low together for exactly OVERLAP_CYC (2) cycles, then return high in the same cycle. The leading output is therefore low for the edge spacing plus 2 cycles.
- R6: While the disable bit or the standby bit is set, both pump outputs are high from the cycle the bit is registered. Any pending request is discarded, so nothing is left to reappear when the bit clears.
- R7: When the lock output is enabled and settling has ended, `lock_o` equals `pump_r_n AND pump_v_n` in every cycle.
- R8: `lock_o` stays low for the first INIT_CYC (8) rising clock edges after reset is released, and may go high from the 8th edge on.
- R9: With the lock-enable bit clear, `lock_o` is low whatever the pump outputs do.
- R10: Control word positions: bit 6 swap, bit 5 disable, bit 4 lock enable, bit 3 standby, bits 2:0 gain. A write takes effect one cycle after the strobe, and `gain_o` follows bits 2:0.
- R11: Edges that arrive during the post-reset settling time produce no request on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_edge | input | 1 | One-cycle strobe per reference period |
| osc_edge | input | 1 | One-cycle strobe per divided-oscillator period |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 7 | Control word (layout in R10) |
| pump_r_n | output | 1 | Active-low request, lag output when not swapped |
| pump_v_n | output | 1 | Active-low request, lead output when not swapped |
| lock_o | output | 1 | Lock indicator |
| gain_o | output | 3 | Gain code for the charge pump |

## Verification
Two functions can land in the same cycle: a new edge on one stream can arrive in the very cycle that the overlap clear fires, and a control write that disables the outputs or flips the swap bit can arrive while a request is pending. The random phase of the bench provokes both by issuing independent edge strobes on the two streams, sometimes in the same cycle, and by interleaving control writes. Each cycle is judged against a requirement-level model of the pending requests, the overlap count and the settling counter. In that model the overlap clear loses to a same-cycle new edge, and a force-idle bit takes effect on the outputs at once while clearing the requests one edge later.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CTRL_W  = 7;
  localparam int GAIN_W  = 3;
  localparam int B_SWAP  = 6;
  localparam int B_OFF   = 5;
  localparam int B_LDEN  = 4;
  localparam int B_SLEEP = 3;

  typedef struct packed {
    logic              swap;
    logic              off;
    logic              lock_en;
    logic              sleep;
    logic [GAIN_W-1:0] gain;
  } pfd_cfg_t;
endpackage

// File: rtl/pfd_ctrl_reg.sv
module pfd_ctrl_reg
  import pfd_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output pfd_cfg_t          cfg
);
  pfd_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= pfd_cfg_t'(RST_VAL);
    else if (we) cfg_q <= pfd_cfg_t'(wdata);
  end

  assign cfg = cfg_q;

  // R10: a write lands on the next edge
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == pfd_cfg_t'($past(wdata))));
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int OVERLAP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic ref_edge,
  input  logic osc_edge,
  output logic up_q,
  output logic dn_q
);
  localparam int CW = $clog2(OVERLAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(OVERLAP_CYC - 1);

  logic [CW-1:0] ovl_q;
  logic          both;
  logic          clr;

  assign both = up_q & dn_q;
  assign clr  = both & (ovl_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else if (hold) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else begin
      up_q  <= clr ? ref_edge : (up_q | ref_edge);
      dn_q  <= clr ? osc_edge : (dn_q | osc_edge);
      ovl_q <= (both && !clr) ? ovl_q + 1'b1 : '0;
    end
  end

  // R5: the overlap ends with both requests dropped together
  p_overlap_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold && !ref_edge && !osc_edge) |=> (!up_q && !dn_q));
  // R6, R11: a held cycle leaves no pending request
  p_hold_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!up_q && !dn_q));
  // R2: a lone oscillator edge always registers a down request
  p_osc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_edge && !hold) |=> dn_q);
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage #(
  parameter int INIT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swap,
  input  logic force_idle,
  input  logic lock_en,
  input  logic up_q,
  input  logic dn_q,
  output logic r_n,
  output logic v_n,
  output logic lock,
  output logic settling
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [IW-1:0] DONE = IW'(INIT_CYC);

  logic [IW-1:0] init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= '0;
    else if (init_q != DONE) init_q <= init_q + 1'b1;
  end

  assign settling = (init_q != DONE);
  assign r_n  = force_idle | ~(swap ? dn_q : up_q);
  assign v_n  = force_idle | ~(swap ? up_q : dn_q);
  assign lock = lock_en & ~settling & r_n & v_n;

  p_idle_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle |-> (r_n && v_n));
  p_lock_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (r_n && v_n));
  p_lock_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q < DONE) |-> !lock);
  p_lock_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |-> !lock);
endmodule

// File: rtl/dual_pump_pfd.sv
module dual_pump_pfd
  import pfd_pkg::*;
#(
  parameter int                OVERLAP_CYC = 2,
  parameter int                INIT_CYC    = 8,
  parameter logic [CTRL_W-1:0] CTRL_RST    = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_edge,
  input  logic              osc_edge,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              pump_r_n,
  output logic              pump_v_n,
  output logic              lock_o,
  output logic [GAIN_W-1:0] gain_o
);
  pfd_cfg_t cfg;
  logic     up_q, dn_q, settling, force_idle, hold;

  assign force_idle = cfg.off | cfg.sleep;
  assign hold       = force_idle | settling;
  assign gain_o     = cfg.gain;

  pfd_ctrl_reg #(.RST_VAL(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .cfg(cfg)
  );

  pfd_core #(.OVERLAP_CYC(OVERLAP_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(hold), .ref_edge(ref_edge),
    .osc_edge(osc_edge), .up_q(up_q), .dn_q(dn_q)
  );

  pfd_out_stage #(.INIT_CYC(INIT_CYC)) u_out (
    .clk(clk), .rst_n(rst_n), .swap(cfg.swap), .force_idle(force_idle),
    .lock_en(cfg.lock_en), .up_q(up_q), .dn_q(dn_q), .r_n(pump_r_n),
    .v_n(pump_v_n), .lock(lock_o), .settling(settling)
  );

  // R4: with swap set, a lone oscillator edge pulls the R line
  p_swap_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.swap && !force_idle && dn_q && !up_q) |-> (!pump_r_n && pump_v_n));
endmodule

// File: tb/sim_dual_pump_pfd.sv
module sim_dual_pump_pfd;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_edge = 1'b0, osc_edge = 1'b0, ctrl_we = 1'b0;
  logic [6:0] ctrl_wdata = '0;
  logic       pump_r_n, pump_v_n, lock_o;
  logic [2:0] gain_o;

  int total = 0, bad = 0;
  bit done = 0;

  // requirement-level model
  logic       m_up, m_dn;
  int         m_cnt, m_init;
  logic [6:0] m_cfg;

  always #5 clk = ~clk;

  dual_pump_pfd u0 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .osc_edge(osc_edge),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .pump_r_n(pump_r_n),
    .pump_v_n(pump_v_n), .lock_o(lock_o), .gain_o(gain_o)
  );

  function automatic logic exp_r();
    logic f = m_cfg[5] | m_cfg[3];
    return f | ~(m_cfg[6] ? m_dn : m_up);
  endfunction
  function automatic logic exp_v();
    logic f = m_cfg[5] | m_cfg[3];
    return f | ~(m_cfg[6] ? m_up : m_dn);
  endfunction
  function automatic logic exp_lock();
    return m_cfg[4] & (m_init >= 8) & exp_r() & exp_v();
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_tick(input logic r, input logic o, input logic we, input logic [6:0] wd);
    logic hold = m_cfg[5] | m_cfg[3] | (m_init < 8);
    logic both = m_up & m_dn;
    logic clr  = both && (m_cnt == 1);
    if (hold) begin
      m_up = 0; m_dn = 0; m_cnt = 0;
    end else begin
      m_up  = clr ? r : (m_up | r);
      m_dn  = clr ? o : (m_dn | o);
      m_cnt = (both && !clr) ? m_cnt + 1 : 0;
    end
    if (we) m_cfg = wd;
    if (m_init < 8) m_init++;
  endtask

  // one clock: drive at negedge, model at posedge, sample at next negedge
  task automatic step(input logic r, input logic o, input logic we, input logic [6:0] wd);
    ref_edge = r; osc_edge = o; ctrl_we = we; ctrl_wdata = wd;
    @(posedge clk);
    model_tick(r, o, we, wd);
    @(negedge clk);
    ref_edge = 0; osc_edge = 0; ctrl_we = 0;
  endtask

  task automatic model_cmp(input string tag);
    chk(pump_r_n, exp_r(), tag);
    chk(pump_v_n, exp_v(), tag);
    chk(lock_o, exp_lock(), tag);
    chk(gain_o, m_cfg[2:0], tag);
  endtask

  // lead = oscillator first by d cycles (d<0: reference first)
  task automatic skew_run(input int d, output int rlow, output int vlow, output int llow);
    rlow = 0; vlow = 0; llow = 0;
    for (int i = 0; i < 12; i++) begin
      logic r = (d >= 0) ? (i == d) : (i == 0);
      logic o = (d >= 0) ? (i == 0) : (i == -d);
      step(r, o, 0, '0);
      rlow += !pump_r_n; vlow += !pump_v_n; llow += !lock_o;
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int rl, vl, ll;
    void'($urandom(32'd4242));
    m_up = 0; m_dn = 0; m_cnt = 0; m_init = 0; m_cfg = 7'h10;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pump_r_n, 1, "R1 r_n"); chk(pump_v_n, 1, "R1 v_n");
    chk(lock_o, 0, "R1 lock"); chk(gain_o, 0, "R1 gain");
    rst_n = 1;
    // R11, R8: settling time, edges ignored
    for (int i = 1; i <= 8; i++) begin
      step(i <= 3, i <= 4, 0, '0);
      if (i <= 6) begin
        chk(pump_v_n, 1, "R11 v_n during settle");
        chk(pump_r_n, 1, "R11 r_n during settle");
      end
      if (i == 7) chk(lock_o, 0, "R8 lock low at edge 7");
      if (i == 8) chk(lock_o, 1, "R8 lock high at edge 8");
    end
    // R2 + R5: oscillator leads by 3
    skew_run(3, rl, vl, ll);
    chk(vl, 5, "R2 v_n low cycles"); chk(rl, 2, "R5 r_n overlap");
    chk(ll, 5, "R7 lock low cycles");
    // R3: reference leads by 2
    skew_run(-2, rl, vl, ll);
    chk(rl, 4, "R3 r_n low cycles"); chk(vl, 2, "R5 v_n overlap");
    // R5: same-cycle edges
    skew_run(0, rl, vl, ll);
    chk(rl, 2, "R5 coincident r_n"); chk(vl, 2, "R5 coincident v_n");
    // R4: swap set, oscillator leads by 2
    step(0, 0, 1, 7'h50);
    skew_run(2, rl, vl, ll);
    chk(rl, 4, "R4 swapped r_n"); chk(vl, 2, "R4 swapped v_n");
    step(0, 0, 1, 7'h10);
    // R6: disable over a pending request
    step(0, 1, 0, '0);
    chk(pump_v_n, 0, "R6 pending before disable");
    step(0, 0, 1, 7'h30);
    chk(pump_v_n, 1, "R6 disable forces v_n high");
    step(0, 0, 0, '0);
    step(0, 0, 1, 7'h10);
    chk(pump_v_n, 1, "R6 no stale after disable");
    chk(pump_r_n, 1, "R6 r_n after disable");
    // R6: standby likewise
    step(1, 0, 0, '0);
    step(0, 0, 1, 7'h18);
    chk(pump_r_n, 1, "R6 standby forces r_n high");
    step(0, 0, 1, 7'h10);
    chk(pump_r_n, 1, "R6 no stale after standby");
    // R9: lock disabled
    step(0, 0, 1, 7'h00);
    chk(lock_o, 0, "R9 lock gated off");
    // R10: gain pass-through
    step(0, 0, 1, 7'h17); chk(gain_o, 7, "R10 gain 7");
    step(0, 0, 1, 7'h12); chk(gain_o, 2, "R10 gain 2");
    step(0, 0, 1, 7'h10);
    // random phase, R2 R3 R4 R5 R6 R7 R9 R10 against the model
    for (int n = 0; n < 4000; n++) begin
      logic r = ($urandom % 5) == 0;
      logic o = ($urandom % 5) == 0;
      logic we = ($urandom % 40) == 0;
      logic [6:0] wd;
      wd[6]   = $urandom % 2;
      wd[5]   = ($urandom % 6) == 0;
      wd[4]   = ($urandom % 4) != 0;
      wd[3]   = ($urandom % 6) == 0;
      wd[2:0] = 3'($urandom);
      step(r, o, we, wd);
      model_cmp("R7 random vs model");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule